// File: doc/BRIEF.md
# Indexed Indirect Register Bank

This peripheral gives software a bank of sixteen-bit registers while taking up only two word addresses on a single-cycle peripheral bus. One address holds a small index register. The other is a shared data window that has no storage of its own. To reach an entry, software first stores its number in the index register. A full-word write to the data window then updates that entry, and a read of the data window returns it.

Each bus transfer completes in one cycle. Read data is driven combinationally in the same cycle as the request. Write data is taken at the next rising clock edge. When the block is not answering a read, its read-data output stays at zero, so it can be OR-combined with the outputs of other peripherals. An index value that is too large wraps modulo the bank size, so no access can fall outside the bank.

Top module: `idx_regbank`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears the index and every bank entry to zero.
- R2: A full-word write (strobes `2'b11`) to the index address (default word address 0x8C) stores the low three bits of the write data. The index therefore wraps modulo the bank size of 8.
- R3: A full-word write to the data address (index address + 1, default 0x8D) updates only the bank entry selected by the current index. All other entries keep their values.
- R4: A read (enabled cycle, strobes `2'b00`) of the data address returns the selected entry on `bus_rdata` in the same cycle.
- R5: `bus_rdata` is all zeros in these cycles: `bus_en` is low, any strobe bit is set, or the address matches neither of the two block addresses.
- R6: A write that raises only one strobe bit (`2'b01` or `2'b10`) changes neither the index nor any bank entry.
- R7: A read of the index address returns the current index, zero-extended to 16 bits.
- R8: Writing the index changes no bank entry. A value written to the data address can be read back from that address in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the design samples on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Marks a bus cycle that is active this clock |
| bus_waddr | input | 14 | Word address of the transfer |
| bus_wdata | input | 16 | Data written into the block |
| bus_wstrb | input | 2 | Byte write strobes: `2'b00` is a read, `2'b11` is a full-word write |
| bus_rdata | output | 16 | Read data; zero when the block is not being read |

## Verification
The assertions assume that every input is stable around the rising clock edge. They also assume that the strobe field means the same thing in every enabled cycle: zero for a read, both bits set for a write. The bench changes all inputs only on the falling edge and samples `bus_rdata` one nanosecond later. This keeps every transfer inside one clock period. The bench also uses every combination of the two strobe bits, including the single-byte cases, so the property that partial writes are ignored is actually exercised. Addresses next to the two decoded locations are driven to check that the decode does not leak to neighbouring addresses.

// File: rtl/idx_regbank_pkg.sv
// Package: shared types for the indexed register bank.
// Assumes a single-cycle bus where strobes 2'b00 mean read and 2'b11 mean a full-word write.
package idx_regbank_pkg;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_IDX_WR = 3'd1,
        ACC_DAT_WR = 3'd2,
        ACC_IDX_RD = 3'd3,
        ACC_DAT_RD = 3'd4
    } acc_kind_t;

    localparam logic [1:0] STRB_READ = 2'b00;
    localparam logic [1:0] STRB_FULL = 2'b11;

endpackage

// File: rtl/idx_regbank_decode.sv
// Module: turns one bus cycle into exactly one access kind.
// Assumes the data window sits one word above the index address.
// Partial-strobe cycles and foreign addresses decode to ACC_NONE.
module idx_regbank_decode
    import idx_regbank_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 14,
    parameter logic [ADDR_W-1:0]    IDX_WADDR = 14'h08C
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [1:0]        wstrb,
    output acc_kind_t         kind
);
    localparam logic [ADDR_W-1:0] DAT_WADDR = IDX_WADDR + 1'b1;

    logic hit_idx;
    logic hit_dat;
    logic is_full;
    logic is_read;

    assign hit_idx = (waddr == IDX_WADDR);
    assign hit_dat = (waddr == DAT_WADDR);
    assign is_full = (wstrb == STRB_FULL);
    assign is_read = (wstrb == STRB_READ);

    // Classify the current bus cycle.
    always_comb begin
        kind = ACC_NONE;
        if (en) begin
            if (hit_idx && is_full)      kind = ACC_IDX_WR;
            else if (hit_dat && is_full) kind = ACC_DAT_WR;
            else if (hit_idx && is_read) kind = ACC_IDX_RD;
            else if (hit_dat && is_read) kind = ACC_DAT_RD;
        end
    end

endmodule

// File: rtl/idx_regbank_index.sv
// Module: index register that selects the bank entry.
// Assumes the bank depth is a power of two, so keeping the low bits is the same as wrapping modulo the depth.
module idx_regbank_index #(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wdata_lo,
    output logic [IDX_W-1:0] idx_q
);

    // Hold the selected entry number; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (wr_en) idx_q <= wdata_lo;
    end

endmodule

// File: rtl/idx_regbank_store.sv
// Module: bank of N data registers with one write port and one read port, both addressed by the index.
// Assumes sel is always inside the bank, which holds because N equals 2**IDX_W.
module idx_regbank_store #(
    parameter int unsigned N_ENTRIES = 8,
    parameter int unsigned DATA_W    = 16,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        // One entry: clears on reset, loads when written and selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 mem[g] <= '0;
            else if (wr_en && (sel == IDX_W'(g)))       mem[g] <= wdata;
        end
    end

    assign rdata = mem[sel];

endmodule

// File: rtl/idx_regbank.sv
// Module: top of the indexed register bank on a single-cycle peripheral bus.
// Two word addresses are used: the index register at IDX_WADDR and the data window at IDX_WADDR+1.
// The read data is zero whenever the block is not being read, so it can be OR-combined with other peripherals.
module idx_regbank
    import idx_regbank_pkg::*;
#(
    parameter int unsigned       N_ENTRIES = 8,
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] IDX_WADDR = 14'h08C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_wstrb,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned IDX_W = $clog2(N_ENTRIES);

    acc_kind_t         kind;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] bank_rd;

    idx_regbank_decode #(
        .ADDR_W    (ADDR_W),
        .IDX_WADDR (IDX_WADDR)
    ) u_decode (
        .en    (bus_en),
        .waddr (bus_waddr),
        .wstrb (bus_wstrb),
        .kind  (kind)
    );

    idx_regbank_index #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (kind == ACC_IDX_WR),
        .wdata_lo (bus_wdata[IDX_W-1:0]),
        .idx_q    (idx_q)
    );

    idx_regbank_store #(
        .N_ENTRIES (N_ENTRIES),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (kind == ACC_DAT_WR),
        .sel   (idx_q),
        .wdata (bus_wdata),
        .rdata (bank_rd)
    );

    // Read mux: index or selected entry, otherwise zero.
    always_comb begin
        case (kind)
            ACC_IDX_RD: bus_rdata = DATA_W'(idx_q);
            ACC_DAT_RD: bus_rdata = bank_rd;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/idx_regbank_chk.sv
// Module: property checker attached to idx_regbank by bind.
// Assumes the inputs are stable around the rising clock edge.
module idx_regbank_chk #(
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       ADDR_W    = 14,
    parameter int unsigned       IDX_W     = 3,
    parameter logic [ADDR_W-1:0] IDX_WADDR = 14'h08C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic [ADDR_W-1:0] bus_waddr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [1:0]        bus_wstrb,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IDX_W-1:0]  idx_q
);
    localparam logic [ADDR_W-1:0] DAT_WADDR = IDX_WADDR + 1'b1;

    logic idx_full_wr;
    logic dat_full_wr;
    logic dat_read;
    assign idx_full_wr = bus_en && (bus_waddr == IDX_WADDR) && (bus_wstrb == 2'b11);
    assign dat_full_wr = bus_en && (bus_waddr == DAT_WADDR) && (bus_wstrb == 2'b11);
    assign dat_read    = bus_en && (bus_waddr == DAT_WADDR) && (bus_wstrb == 2'b00);

    // R1
    reset_clears_index_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (idx_q == '0));

    // R5
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_rdata == '0));

    // R5
    write_cycle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && (bus_wstrb != 2'b00)) |-> (bus_rdata == '0));

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_full_wr |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

    // R6
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_full_wr |=> $stable(idx_q));

    // R7
    index_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && (bus_waddr == IDX_WADDR) && (bus_wstrb == 2'b00)) |-> (bus_rdata == DATA_W'(idx_q)));

    // R8
    data_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_full_wr |=> (!dat_read || (bus_rdata == $past(bus_wdata))));

endmodule

bind idx_regbank idx_regbank_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .IDX_WADDR (IDX_WADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .bus_wstrb (bus_wstrb),
    .bus_rdata (bus_rdata),
    .idx_q     (idx_q)
);

// File: tb/idx_regbank_bench.sv
// Bench: sweeps the index and the data patterns, and checks results against a model of the bank kept in the bench.
module idx_regbank_bench;

    localparam logic [13:0] IDX_A = 14'h08C;
    localparam logic [13:0] DAT_A = 14'h08D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic [13:0] bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_wstrb = '0;
    logic [15:0] bus_rdata;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [15:0] model [8];
    logic [2:0]  m_idx;

    idx_regbank u_idx_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_rdata (bus_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive on the falling edge, sample rdata 1 ns later.
    task automatic cyc(input logic en, input logic [13:0] a, input logic [15:0] d,
                       input logic [1:0] s, input string req, input logic [15:0] exp);
        @(negedge clk);
        bus_en = en; bus_waddr = a; bus_wdata = d; bus_wstrb = s;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr_idx(input logic [15:0] v);
        cyc(1'b1, IDX_A, v, 2'b11, "R5", 16'h0);
        m_idx = v[2:0];
    endtask

    task automatic wr_dat(input logic [15:0] v);
        cyc(1'b1, DAT_A, v, 2'b11, "R5", 16'h0);
        model[m_idx] = v;
    endtask

    task automatic sweep_read(input string req);
        for (int i = 0; i < 8; i++) begin
            wr_idx(16'(i));
            cyc(1'b1, IDX_A, 16'hFFFF, 2'b00, "R7", 16'(i));
            cyc(1'b1, DAT_A, 16'hFFFF, 2'b00, req, model[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        m_idx = 3'd0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        m_idx = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: index and all entries are zero after reset
        cyc(1'b0, DAT_A, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, IDX_A, 16'h0, 2'b00, "R1", 16'h0);
        cyc(1'b1, DAT_A, 16'h0, 2'b00, "R1", 16'h0);
        sweep_read("R1");

        // R3/R4: pattern sweep, one entry per index, several patterns
        for (int p = 0; p < 24; p++) begin
            for (int e = 0; e < 8; e++) begin
                wr_idx(16'(e));
                wr_dat(16'((e * 16'h1357) ^ (p * 16'h2468) ^ 16'h5A00));
                // R8: read back in the following cycle
                cyc(1'b1, DAT_A, 16'h0, 2'b00, "R8", model[e]);
            end
            sweep_read("R3");
        end

        // R2: high index bits wrap modulo 8; R8: the bank is untouched
        for (int v = 0; v < 64; v++) begin
            wr_idx(16'(v * 16'h0409 + 16'h0008));
            cyc(1'b1, IDX_A, 16'h0, 2'b00, "R2", {13'h0, m_idx});
            cyc(1'b1, DAT_A, 16'h0, 2'b00, "R4", model[m_idx]);
        end
        sweep_read("R8");

        // R6: single-strobe writes to either address change nothing
        wr_idx(16'h0005);
        for (int s = 1; s < 3; s++) begin
            cyc(1'b1, IDX_A, 16'h0002, 2'(s), "R5", 16'h0);
            cyc(1'b1, IDX_A, 16'h0, 2'b00, "R6", 16'h0005);
            cyc(1'b1, DAT_A, 16'hDEAD, 2'(s), "R5", 16'h0);
            cyc(1'b1, DAT_A, 16'h0, 2'b00, "R6", model[5]);
        end
        sweep_read("R6");

        // R5: disabled reads, and neighbouring or distant addresses return zero
        cyc(1'b0, IDX_A, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b0, DAT_A, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, 14'h08B, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, 14'h08E, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, 14'h0000, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, 14'h3FFF, 16'h0, 2'b00, "R5", 16'h0);
        cyc(1'b1, 14'h108D, 16'h0, 2'b00, "R5", 16'h0);
        // R3: a full write to a foreign address leaves the bank unchanged
        cyc(1'b1, 14'h08E, 16'hBEEF, 2'b11, "R5", 16'h0);
        sweep_read("R3");

        // R1: a reset in the middle of a run clears everything again
        do_reset();
        cyc(1'b1, IDX_A, 16'h0, 2'b00, "R1", 16'h0);
        sweep_read("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule